// File: doc/BRIEF.md
# Oversampling Serial Receiver with Center-Sample Voting

This block receives asynchronous serial frames on a single line. An external rate generator supplies a one-cycle sample enable at 16 times the bit rate, or at 8 times when the double-rate input is set. The line passes through a two-flop synchronizer. The receiver then searches for a high-to-low transition between two consecutive samples. From that sample on, it counts samples through each bit period and decides every bit by a two-of-three vote over the samples at the middle of the bit.

A frame is a start bit, followed by 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and a stop bit. Only the first stop bit is judged. The receiver goes back to searching for a start edge on the same sample that decides the stop bit, so a line that shortens the stop bit is still followed correctly.

Each finished frame goes out through a valid/ready stream port. The word and its two error flags stay stable while `out_valid` is high and `out_ready` is low. The line cannot be stalled, so a frame that finishes while an earlier word is still waiting replaces that earlier word. If the consumer takes the old word in the same cycle that a new frame finishes, the old word counts as delivered and the new word is presented in the next cycle.

Top module: `uart_os_rx`

## Requirements
- R1: With `dbl_rate` low a bit spans 16 sample ticks, and with it high a bit spans 8. Counting the tick that first sees the start bit low as sample 1, the vote uses samples 8, 9 and 10 in 16x mode and samples 4, 5 and 6 in 8x mode, and all other samples are ignored.
- R2: A bit is decided as 1 when at least two of its three vote samples are high, and as 0 otherwise.
- R3: While searching, a start edge is a high sample followed by a low sample on the next tick. If the start bit's own vote comes out high, the receiver returns to searching and produces no word.
- R4: `len_sel` selects the data length as 0→5, 1→6, 2→7 and 3→8 bits. Data bits arrive least significant first. The word is right-aligned in `out_data`, and its unused upper bits are 0.
- R5: `par_sel` selects the parity mode as 0 or 3 → no parity bit, 1 → even, 2 → odd. The parity bit follows the last data bit. `out_perr` is 1 when the decided parity bit does not give the selected parity over the decided data bits, and it is always 0 when parity is off.
- R6: Only the first stop bit is judged, with the same vote. A vote that comes out low sets `out_ferr`, and the data word is still delivered.
- R7: The receiver resumes searching for a start edge on the same tick that decides the stop bit. A high at that vote sample followed by a low on the next tick starts a new frame.
- R8: `rxd_in` is synchronized by two flops and is observed only on cycles where `samp_tick` is high. A line pulse that no tick observes has no effect.
- R9: `out_valid` rises on the clock edge at which the stop bit is decided. While `out_valid` is high and `out_ready` is low, `out_data`, `out_ferr` and `out_perr` hold. A handshake with no new frame in the same cycle clears `out_valid`.
- R10: A frame that completes while a word is still waiting overwrites that word. If a handshake falls in the same cycle as a frame completion, the old word is delivered and `out_valid` stays high with the new word.
- R11: During and after reset, `out_valid`, `out_ferr` and `out_perr` are 0 and the receiver is searching, with the line treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle sample enable at 16x or 8x the bit rate |
| dbl_rate | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| len_sel | input | 2 | Data length code, 5 + code bits |
| par_sel | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| out_valid | output | 1 | Received word available |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 8 | Received data, right-aligned |
| out_ferr | output | 1 | Stop bit voted low |
| out_perr | output | 1 | Parity mismatch |

## Verification
Two functions can fall in the same cycle: the output handshake and the completion of a new frame, which happens on the tick that decides the stop bit. The bench holds `out_ready` low while two frames arrive and raises it for exactly the cycle of the second frame's stop-bit vote tick. It then expects the first word to be taken in that cycle and the second word to remain presented with `out_valid` still high. A second directed case, with `out_ready` held low throughout, expects only the later word to survive.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF3 = 2'd3
  } par_sel_e;

  typedef enum logic [2:0] {
    RX_HUNT  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler
  import uart_os_rx_pkg::*;
#(
  parameter int OSR_HI = 16,
  parameter int OSR_LO = 8,
  parameter int CNT_W  = $clog2(OSR_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dbl,
  input  logic hunt,
  input  logic rx_s,
  output logic start_seen,
  output logic bit_done,
  output logic bit_val
);
  localparam logic [CNT_W-1:0] SPAN_HI = CNT_W'(OSR_HI);
  localparam logic [CNT_W-1:0] SPAN_LO = CNT_W'(OSR_LO);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span, ctr0, ctr1, ctr2, nxt;
  logic             prev;
  logic [1:0]       votes;

  always_comb begin
    span = dbl ? SPAN_LO : SPAN_HI;
    ctr0 = span >> 1;
    ctr1 = ctr0 + ONE;
    ctr2 = ctr1 + ONE;
    nxt  = (cnt >= span) ? ONE : cnt + ONE;
  end

  assign start_seen = tick & hunt & prev & ~rx_s;
  assign bit_done   = tick & ~hunt & (nxt == ctr2);
  assign bit_val    = vote3(votes[0], votes[1], rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      prev  <= 1'b1;
      votes <= '0;
    end else if (tick) begin
      prev <= rx_s;
      if (hunt) begin
        cnt <= start_seen ? ONE : '0;
      end else begin
        cnt <= nxt;
        if (nxt == ctr0) votes[0] <= rx_s;
        if (nxt == ctr1) votes[1] <= rx_s;
      end
    end
  end

  // R1: outside the search the sample index always lies inside the bit period
  a_r1_index_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |-> (cnt >= ONE && cnt <= span))
    else $error("sample index out of range");

  // R8: the sample history moves only on a tick
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(prev) && $stable(cnt))
    else $error("sampler moved without a tick");
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = MAX_BITS + 1 - (1 << LEN_W),
  parameter int BC_W     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_seen,
  input  logic                bit_done,
  input  logic                bit_val,
  input  logic [LEN_W-1:0]    len_code,
  input  logic [1:0]          par_code,
  output logic                hunt,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] frame_data,
  output logic                frame_ferr,
  output logic                frame_perr
);
  localparam logic [BC_W-1:0] ONE = BC_W'(1);

  rx_state_e           state;
  logic [MAX_BITS-1:0] shreg;
  logic [BC_W-1:0]     bcnt, nbits;
  logic                par_acc, perr_r, par_en, par_odd, last_bit;

  always_comb begin
    nbits    = BC_W'(MIN_BITS) + BC_W'(len_code);
    last_bit = (bcnt == nbits - ONE);
    par_en   = (par_code == PAR_EVEN) || (par_code == PAR_ODD);
    par_odd  = (par_code == PAR_ODD);
  end

  assign hunt       = (state == RX_HUNT);
  assign frame_done = (state == RX_STOP) & bit_done;
  assign frame_ferr = ~bit_val;
  assign frame_perr = perr_r;
  assign frame_data = shreg >> (BC_W'(MAX_BITS) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_HUNT;
      shreg   <= '0;
      bcnt    <= '0;
      par_acc <= 1'b0;
      perr_r  <= 1'b0;
    end else begin
      case (state)
        RX_HUNT: if (start_seen) state <= RX_START;
        RX_START: if (bit_done) begin
          state   <= bit_val ? RX_HUNT : RX_DATA;
          shreg   <= '0;
          bcnt    <= '0;
          par_acc <= 1'b0;
          perr_r  <= 1'b0;
        end
        RX_DATA: if (bit_done) begin
          shreg   <= {bit_val, shreg[MAX_BITS-1:1]};
          par_acc <= par_acc ^ bit_val;
          bcnt    <= bcnt + ONE;
          if (last_bit) state <= par_en ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (bit_done) begin
          perr_r <= par_acc ^ bit_val ^ par_odd;
          state  <= RX_STOP;
        end
        RX_STOP: if (bit_done) state <= RX_HUNT;
        default: state <= RX_HUNT;
      endcase
    end
  end

  // R4: the data bit count never passes the selected length
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state == RX_DATA |-> bcnt < nbits)
    else $error("data bit count overran");

  // R3: a start bit voted high sends the receiver back to the search
  a_r3_glitch_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && bit_done && bit_val) |=> hunt)
    else $error("false start not rejected");

  // R7: the search resumes right after the stop vote
  a_r7_hunt_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_STOP && bit_done) |=> hunt)
    else $error("no search after stop bit");

  // R5: without parity the last data bit leads straight to the stop bit
  a_r5_skip_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && bit_done && last_bit && !par_en) |=> state == RX_STOP)
    else $error("parity slot used with parity off");
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2,
  parameter int OSR_HI   = 16,
  parameter int OSR_LO   = 8,
  parameter int SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_tick,
  input  logic                dbl_rate,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic [1:0]          par_sel,
  input  logic                rxd_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MAX_BITS-1:0] out_data,
  output logic                out_ferr,
  output logic                out_perr
);
  logic                rx_s, start_seen, bit_done, bit_val, hunt;
  logic                frame_done, frame_ferr, frame_perr;
  logic [MAX_BITS-1:0] frame_data;

  uart_os_rx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd_in), .q(rx_s)
  );

  uart_os_rx_sampler #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(samp_tick), .dbl(dbl_rate), .hunt(hunt),
    .rx_s(rx_s), .start_seen(start_seen), .bit_done(bit_done), .bit_val(bit_val)
  );

  uart_os_rx_frame #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .bit_done(bit_done),
    .bit_val(bit_val), .len_code(len_sel), .par_code(par_sel), .hunt(hunt),
    .frame_done(frame_done), .frame_data(frame_data), .frame_ferr(frame_ferr),
    .frame_perr(frame_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
      out_perr  <= 1'b0;
    end else if (frame_done) begin
      out_valid <= 1'b1;
      out_data  <= frame_data;
      out_ferr  <= frame_ferr;
      out_perr  <= frame_perr;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a finished frame is presented on the next cycle
  a_r9_present: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid)
    else $error("finished frame not presented");

  // R9: back-pressure holds the word
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_done) |=>
      out_valid && $stable(out_data) && $stable(out_ferr) && $stable(out_perr))
    else $error("word changed under back-pressure");

  // R9: a handshake without a new frame empties the port
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_done) |=> !out_valid)
    else $error("valid stayed after handshake");

  // R10: a frame completing in a handshake cycle keeps valid high
  a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && frame_done) |=> out_valid)
    else $error("new frame lost in handshake cycle");
endmodule

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b0;
  logic       dbl_rate = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] par_sel = 2'd0;
  logic       rxd_in = 1'b1;
  logic       out_ready;
  logic       out_valid, out_ferr, out_perr;
  logic [7:0] out_data;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   rdy_mode = 1'b0;
  bit   rdy_force = 1'b0;
  logic [9:0] expq[$];
  string cur_req = "R1 R2 R4";

  always #2.5 clk = ~clk;

  uart_os_rx uut (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .dbl_rate(dbl_rate),
    .len_sel(len_sel), .par_sel(par_sel), .rxd_in(rxd_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ferr(out_ferr), .out_perr(out_perr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {perr, ferr, data} from decided bit values
  function automatic logic [9:0] expect_word(input logic [7:0] dd, input int lc,
                                             input int pm, input logic pbit, input bit sbad);
    logic [7:0] m;
    logic pe;
    m  = 8'((1 << (5 + lc)) - 1);
    pe = (pm == 1 || pm == 2) ? ((^(dd & m)) ^ pbit ^ (pm == 2)) : 1'b0;
    return {pe, sbad, dd & m};
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input int lc, input int pm);
    logic [7:0] m;
    m = 8'((1 << (5 + lc)) - 1);
    return (^(d & m)) ^ (pm == 2);
  endfunction

  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      out_ready = rdy_mode ? rdy_force : 1'($urandom % 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected word"}, {22'd0, out_perr, out_ferr, out_data}, 32'd0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({out_perr, out_ferr, out_data} == e, cur_req,
            {22'd0, out_perr, out_ferr, out_data}, {22'd0, e});
      end
    end
  end

  task automatic put_sample(input logic v, input bit coll);
    @(posedge clk); #1 rxd_in = v;
    repeat (3) @(posedge clk);
    #1 samp_tick = 1'b1;
    if (coll) rdy_force = 1'b1;
    @(posedge clk); #1 samp_tick = 1'b0;
    if (coll) rdy_force = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_sample(1'b1, 1'b0);
  endtask

  task automatic send_bit(input logic nom, input logic [2:0] fm, input bit noise,
                          input int nsamp, input int coll_at);
    int span, c0;
    span = dbl_rate ? 8 : 16;
    c0 = span / 2;
    for (int s = 1; s <= nsamp; s++) begin
      logic v;
      v = nom;
      if (s == c0 && fm[0]) v = ~v;
      if (s == c0 + 1 && fm[1]) v = ~v;
      if (s == c0 + 2 && fm[2]) v = ~v;
      if (noise && (s == 2 || s == span - 1) && ($urandom % 2 == 1)) v = ~v;
      put_sample(v, s == coll_at);
    end
  endtask

  function automatic logic [2:0] one_flip(input bit rnd);
    if (!rnd || $urandom % 2 == 0) return 3'b000;
    return 3'b001 << ($urandom % 3);
  endfunction

  task automatic send_frame(input logic [7:0] d, input int lc, input int pm, input bit dbl,
                            input bit pflip, input bit sbad, input int flip2, input bit short_stop,
                            input bit collide, input bit rnd, input bit push);
    int span, nb;
    logic [7:0] dd;
    logic pb;
    dbl_rate = dbl;
    len_sel  = 2'(lc);
    par_sel  = 2'(pm);
    span = dbl ? 8 : 16;
    nb = 5 + lc;
    dd = (flip2 >= 0) ? (d ^ 8'(1 << flip2)) : d;
    pb = par_bit(d, lc, pm) ^ pflip;
    if (push) expq.push_back(expect_word(dd, lc, pm, pb, sbad));
    send_bit(1'b0, one_flip(rnd), 1'b0, span, 0);
    for (int i = 0; i < nb; i++)
      send_bit(d[i], (i == flip2) ? 3'b110 : one_flip(rnd), rnd, span, 0);
    if (pm == 1 || pm == 2) send_bit(pb, one_flip(rnd), rnd, span, 0);
    send_bit(1'b1, sbad ? 3'b011 : ((rnd && !short_stop && $urandom % 2 == 1) ? 3'b001 : 3'b000),
             1'b0, short_stop ? span / 2 + 2 : span, collide ? span / 2 + 2 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, %0d words outstanding", expq.size());
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0 && out_ferr == 1'b0 && out_perr == 1'b0, "R11 reset outputs",
        {29'd0, out_valid, out_ferr, out_perr}, 32'd0);
    #1 rst_n = 1'b1;
    idle(4);

    // R8: a low pulse no tick observes is invisible
    cur_req = "R8";
    #1 rxd_in = 1'b0;
    @(posedge clk); #1 rxd_in = 1'b1;
    idle(40);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 untimed pulse", {31'd0, out_valid}, 32'd0);

    // R1 R2 R4: clean frames in both rates
    cur_req = "R1 R2 R4 directed";
    send_frame(8'hA5, 3, 0, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(3);
    send_frame(8'h16, 0, 0, 1'b1, 0, 0, -1, 0, 0, 0, 1); idle(3);
    // R2: two corrupted centres flip the decided bit
    cur_req = "R2 majority flip";
    send_frame(8'h3C, 3, 0, 1'b0, 0, 0, 2, 0, 0, 0, 1); idle(3);
    send_frame(8'h55, 2, 0, 1'b1, 0, 0, 0, 0, 0, 1, 1); idle(3);
    // R5: parity good and bad, both senses
    cur_req = "R5 parity";
    send_frame(8'h6B, 3, 1, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(3);
    send_frame(8'h6B, 3, 1, 1'b0, 1, 0, -1, 0, 0, 0, 1); idle(3);
    send_frame(8'h13, 0, 2, 1'b1, 1, 0, -1, 0, 0, 0, 1); idle(3);
    send_frame(8'h2E, 1, 2, 1'b0, 0, 0, -1, 0, 0, 1, 1); idle(3);
    send_frame(8'h71, 2, 3, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(3);
    // R6: bad stop bit, data still delivered
    cur_req = "R6 frame error";
    send_frame(8'hC3, 3, 0, 1'b0, 0, 1, -1, 0, 0, 0, 1); idle(3);
    send_frame(8'h0F, 1, 1, 1'b1, 0, 1, -1, 0, 0, 0, 1); idle(3);

    // R3: short low glitch is rejected, receiver recovers
    cur_req = "R3 glitch";
    put_sample(1'b0, 1'b0); put_sample(1'b0, 1'b0);
    idle(30);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 glitch gave no word", {31'd0, out_valid}, 32'd0);
    send_frame(8'h9A, 3, 0, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(3);

    // R7: stop bit cut right after its vote, next start follows at once
    cur_req = "R7 early search";
    send_frame(8'hE7, 3, 0, 1'b0, 0, 0, -1, 1, 0, 0, 1);
    send_frame(8'h18, 3, 1, 1'b0, 0, 0, -1, 1, 0, 0, 1);
    send_frame(8'h0B, 0, 0, 1'b1, 0, 0, -1, 1, 0, 0, 1);
    send_frame(8'h1D, 0, 2, 1'b1, 0, 0, -1, 0, 0, 0, 1); idle(4);

    // R10: overwrite under back-pressure
    cur_req = "R10 overwrite";
    rdy_mode = 1'b1; rdy_force = 1'b0;
    idle(2);
    send_frame(8'h11, 3, 0, 1'b0, 0, 0, -1, 0, 0, 0, 0); idle(2);
    send_frame(8'h22, 3, 0, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(2);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 8'h22, "R10 newer word kept",
        {23'd0, out_valid, out_data}, {23'd0, 1'b1, 8'h22});
    rdy_mode = 1'b0;
    idle(3);

    // R10: handshake and completion in one cycle
    cur_req = "R10 same-cycle";
    rdy_mode = 1'b1; rdy_force = 1'b0;
    idle(2);
    send_frame(8'h44, 3, 0, 1'b0, 0, 0, -1, 0, 0, 0, 1); idle(2);
    send_frame(8'h88, 3, 2, 1'b0, 0, 0, -1, 0, 1, 0, 1); idle(1);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 8'h88 && expq.size() == 1, "R10 R9 second word held",
        {22'd0, out_valid, 1'(expq.size()), out_data}, {22'd0, 1'b1, 1'b1, 8'h88});
    rdy_mode = 1'b0;
    idle(3);

    // random frames
    cur_req = "R1 R2 R4 R5 R6 R7 random";
    for (int k = 0; k < 60; k++) begin
      bit ss;
      ss = ($urandom % 6 == 0);
      send_frame(8'($urandom), int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2),
                 ($urandom % 8 == 0), ($urandom % 8 == 0), -1, ss, 0, 1, 1);
      if (!ss) idle(1 + int'($urandom % 4));
    end
    idle(20);
    @(negedge clk);
    chk(expq.size() == 0, "R9 all words delivered", expq.size(), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule